// File: doc/BRIEF.md
# MAC Control Frame Receive Classifier

This block sits on the receive path of an Ethernet MAC and watches a byte-wide stream of frames (one byte per valid beat, a last marker and a per-frame error bit that comes with the last beat). It picks out MAC control frames by comparing the header against configured values. The destination, source, EtherType and opcode are each compared against their own configured value. The destination and source checks and the two opcode decodes can each be switched on or off on their own, and the whole classifier has one master enable.

The stream passes through with one cycle of latency. A frame is recognised as a control frame when its header matches and its opcode equals either the configured link-level pause opcode or the configured per-class pause opcode. Once recognised, it is either forwarded unchanged or flagged bad by setting the error bit on its last beat, depending on a forwarding setting. When a recognised frame also arrived with a good FCS, the block raises a single-cycle request to the pause logic. The request carries the pause time from the frame, or the class-enable byte and all per-class pause times.

Top module: `mcf_rx_classifier`

## Requirements
- R1: While reset is held and in the first cycle after it, `outValid`, `lfcReq` and `pfcReq` are low.
- R2: Every input beat appears on the output exactly one clock later with the same data byte and last marker. For a frame that is not recognised, `outUser` on its last beat equals `inUser`.
- R3: A frame can be recognised only when `cfgEnable` is high and bytes 12–13 (byte 12 the high byte) equal `cfgEthType`. Otherwise neither marking nor a request happens.
- R4: If `cfgMcastChk` or `cfgUcastChk` is set, bytes 0–5 (byte 0 most significant) must equal an enabled one of `cfgMcastAddr` or `cfgUcastAddr`. With both checks clear, any destination passes.
- R5: When `cfgSrcChk` is set, bytes 6–11 must equal `cfgSrcAddr`. When it is clear, the source is not compared.
- R6: A frame is a link pause frame when `cfgLfcChk` is set and bytes 14–15 equal `cfgLfcOpcode`. For such a frame, `lfcReq` is high in the cycle that its last beat is on the output, and `lfcQuanta` shows bytes 16–17 big-endian. `lfcQuanta` changes only together with `lfcReq`.
- R7: A frame is a class pause frame when `cfgPfcChk` is set, bytes 14–15 equal `cfgPfcOpcode` and it is not a link pause frame. For such a frame, `pfcReq` is high in the cycle that its last beat is on the output. `pfcClassEn` then shows byte 17, the low byte of the class-enable word. `pfcQuanta[16k+15:16k]` shows bytes 18+2k and 19+2k big-endian, for classes k = 0..7.
- R8: With `cfgForward` low, a recognised frame leaves with `outUser` set on its last beat. With `cfgForward` high, its `outUser` equals `inUser`.
- R9: A recognised frame whose last beat has `inUser` set raises no request, but is still marked as in R8.
- R10: A frame shorter than 18 bytes is never a link pause frame, and a frame shorter than 34 bytes is never a class pause frame. Such a frame is neither marked nor raises a request.
- R11: Each request is high for exactly one cycle per recognised frame, including when frames arrive back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input byte valid |
| inData | input | 8 | Input byte |
| inLast | input | 1 | Last byte of frame |
| inUser | input | 1 | Frame error (bad FCS), meaningful on last byte |
| outValid | output | 1 | Output byte valid |
| outData | output | 8 | Output byte |
| outLast | output | 1 | Last byte of frame |
| outUser | output | 1 | Frame error or control-frame mark |
| cfgEnable | input | 1 | Master enable of the classifier |
| cfgMcastAddr | input | 48 | Multicast destination to match |
| cfgMcastChk | input | 1 | Enable multicast destination compare |
| cfgUcastAddr | input | 48 | Unicast destination to match |
| cfgUcastChk | input | 1 | Enable unicast destination compare |
| cfgSrcAddr | input | 48 | Source address to match |
| cfgSrcChk | input | 1 | Enable source compare |
| cfgEthType | input | 16 | Control EtherType (normally 0x8808) |
| cfgLfcOpcode | input | 16 | Link pause opcode (normally 0x0001) |
| cfgLfcChk | input | 1 | Enable link pause decode |
| cfgPfcOpcode | input | 16 | Class pause opcode (normally 0x0101) |
| cfgPfcChk | input | 1 | Enable class pause decode |
| cfgForward | input | 1 | Forward recognised frames unmarked |
| lfcReq | output | 1 | Link pause request pulse |
| lfcQuanta | output | 16 | Link pause time |
| pfcReq | output | 1 | Class pause request pulse |
| pfcClassEn | output | 8 | Class-enable bits |
| pfcQuanta | output | 128 | Per-class pause times, class k in bits 16k+15:16k |

## Verification
On the last beat of a recognised frame, the block has to both set the error mark on the output and pulse a request, all in the same output cycle. The bench sends pause frames with forwarding off and checks, on that one output beat, the marked `outUser`, the request pulse and its captured pause times together. It also sends a link pause frame straight into a class pause frame with no idle gap. There, a new frame's first byte is taken in during the same cycle that the previous frame's request and mark come out. Each output beat is checked against the scoreboard entry for that beat, so any slip of the mark or the pulse by one cycle shows as a mismatch.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 48;
  localparam int QW     = 16;
  localparam int NCLS   = 8;
  localparam int LFC_MIN_LEN = 18;
  localparam int PFC_MIN_LEN = LFC_MIN_LEN + NCLS * 2;
  localparam int CNT_W  = $clog2(PFC_MIN_LEN + 1);

  localparam logic [CNT_W-1:0] OFF_SRC  = CNT_W'(6);
  localparam logic [CNT_W-1:0] OFF_TYPE = CNT_W'(12);
  localparam logic [CNT_W-1:0] OFF_OP   = CNT_W'(14);
  localparam logic [CNT_W-1:0] OFF_ARG  = CNT_W'(16);
  localparam logic [CNT_W-1:0] OFF_Q    = CNT_W'(LFC_MIN_LEN);
  localparam logic [CNT_W-1:0] OFF_END  = CNT_W'(PFC_MIN_LEN);

  typedef struct packed {
    logic [ADDR_W-1:0]  dst;
    logic [ADDR_W-1:0]  src;
    logic [QW-1:0]      etype;
    logic [QW-1:0]      opcode;
    logic [QW-1:0]      arg0;
    logic [NCLS*QW-1:0] quanta;
  } hdr_t;

  typedef struct packed {
    logic markBad;
    logic lfcFire;
    logic pfcFire;
  } strobe_t;
endpackage

// File: rtl/mcf_control.sv
module mcf_control
  import mcf_pkg::*;
(
  input  logic              inValid,
  input  logic              inLast,
  input  logic              inUser,
  input  hdr_t              hdrNow,
  input  logic [CNT_W-1:0]  lenNow,
  input  logic              cfgEnable,
  input  logic [ADDR_W-1:0] cfgMcastAddr,
  input  logic              cfgMcastChk,
  input  logic [ADDR_W-1:0] cfgUcastAddr,
  input  logic              cfgUcastChk,
  input  logic [ADDR_W-1:0] cfgSrcAddr,
  input  logic              cfgSrcChk,
  input  logic [QW-1:0]     cfgEthType,
  input  logic [QW-1:0]     cfgLfcOpcode,
  input  logic              cfgLfcChk,
  input  logic [QW-1:0]     cfgPfcOpcode,
  input  logic              cfgPfcChk,
  input  logic              cfgForward,
  output strobe_t           strobe
);
  logic dstOk, srcOk, hdrOk, lfcHit, pfcHit, endBeat;

  always_comb begin
    dstOk = (!cfgMcastChk && !cfgUcastChk)
         || (cfgMcastChk && hdrNow.dst == cfgMcastAddr)
         || (cfgUcastChk && hdrNow.dst == cfgUcastAddr);
    srcOk = !cfgSrcChk || (hdrNow.src == cfgSrcAddr);
    hdrOk = cfgEnable && dstOk && srcOk && (hdrNow.etype == cfgEthType);
    lfcHit = hdrOk && cfgLfcChk && (hdrNow.opcode == cfgLfcOpcode)
          && (lenNow >= OFF_Q);
    pfcHit = hdrOk && cfgPfcChk && (hdrNow.opcode == cfgPfcOpcode)
          && (lenNow >= OFF_END) && !lfcHit;
    endBeat = inValid && inLast;
    strobe.markBad = endBeat && (lfcHit || pfcHit) && !cfgForward;
    strobe.lfcFire = endBeat && lfcHit && !inUser;
    strobe.pfcFire = endBeat && pfcHit && !inUser;
  end
endmodule

// File: rtl/mcf_datapath.sv
module mcf_datapath
  import mcf_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [BYTE_W-1:0]   inData,
  input  logic                inLast,
  input  logic                inUser,
  input  strobe_t             strobe,
  output hdr_t                hdrNow,
  output logic [CNT_W-1:0]    lenNow,
  output logic                outValid,
  output logic [BYTE_W-1:0]   outData,
  output logic                outLast,
  output logic                outUser,
  output logic                lfcReq,
  output logic [QW-1:0]       lfcQuanta,
  output logic                pfcReq,
  output logic [NCLS-1:0]     pfcClassEn,
  output logic [NCLS*QW-1:0]  pfcQuanta
);
  logic [CNT_W-1:0]   cnt;
  hdr_t               hdrQ;
  logic [NCLS*QW-1:0] qReg;

  always_comb begin
    hdrNow = hdrQ;
    if (inValid) begin
      if (cnt < OFF_SRC)       hdrNow.dst    = {hdrQ.dst[ADDR_W-BYTE_W-1:0], inData};
      else if (cnt < OFF_TYPE) hdrNow.src    = {hdrQ.src[ADDR_W-BYTE_W-1:0], inData};
      else if (cnt < OFF_OP)   hdrNow.etype  = {hdrQ.etype[QW-BYTE_W-1:0], inData};
      else if (cnt < OFF_ARG)  hdrNow.opcode = {hdrQ.opcode[QW-BYTE_W-1:0], inData};
      else if (cnt < OFF_Q)    hdrNow.arg0   = {hdrQ.arg0[QW-BYTE_W-1:0], inData};
      else if (cnt < OFF_END)  hdrNow.quanta = {hdrQ.quanta[NCLS*QW-BYTE_W-1:0], inData};
    end
  end

  assign lenNow = (cnt == '1) ? cnt : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      hdrQ <= '0;
    end else if (inValid) begin
      if (inLast) begin
        cnt  <= '0;
        hdrQ <= '0;
      end else begin
        cnt  <= lenNow;
        hdrQ <= hdrNow;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid   <= 1'b0;
      outData    <= '0;
      outLast    <= 1'b0;
      outUser    <= 1'b0;
      lfcReq     <= 1'b0;
      pfcReq     <= 1'b0;
      lfcQuanta  <= '0;
      pfcClassEn <= '0;
      qReg       <= '0;
    end else begin
      outValid <= inValid;
      outData  <= inData;
      outLast  <= inLast;
      outUser  <= inUser | strobe.markBad;
      lfcReq   <= strobe.lfcFire;
      pfcReq   <= strobe.pfcFire;
      if (strobe.lfcFire) lfcQuanta <= hdrNow.arg0;
      if (strobe.pfcFire) begin
        pfcClassEn <= hdrNow.arg0[NCLS-1:0];
        qReg       <= hdrNow.quanta;
      end
    end
  end

  // the first class shifted in lands in the top slot; reverse to class order
  for (genvar k = 0; k < NCLS; k++) begin : g_cls
    assign pfcQuanta[k*QW +: QW] = qReg[(NCLS-1-k)*QW +: QW];
  end

  AST_REQ_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    (lfcReq || pfcReq) |-> (outValid && outLast)); // R6
  AST_LFC_QUANTA_HELD: assert property (@(posedge clk) disable iff (rst)
    !lfcReq |-> $stable(lfcQuanta)); // R6
  AST_REQ_FCS_GOOD: assert property (@(posedge clk) disable iff (rst)
    (lfcReq || pfcReq) |-> !$past(inUser)); // R9
  AST_LFC_PULSE: assert property (@(posedge clk) disable iff (rst)
    lfcReq |=> !lfcReq); // R11
  AST_PFC_PULSE: assert property (@(posedge clk) disable iff (rst)
    pfcReq |=> !pfcReq); // R11
endmodule

// File: rtl/mcf_rx_classifier.sv
module mcf_rx_classifier
  import mcf_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [7:0]          inData,
  input  logic                inLast,
  input  logic                inUser,
  output logic                outValid,
  output logic [7:0]          outData,
  output logic                outLast,
  output logic                outUser,
  input  logic                cfgEnable,
  input  logic [47:0]         cfgMcastAddr,
  input  logic                cfgMcastChk,
  input  logic [47:0]         cfgUcastAddr,
  input  logic                cfgUcastChk,
  input  logic [47:0]         cfgSrcAddr,
  input  logic                cfgSrcChk,
  input  logic [15:0]         cfgEthType,
  input  logic [15:0]         cfgLfcOpcode,
  input  logic                cfgLfcChk,
  input  logic [15:0]         cfgPfcOpcode,
  input  logic                cfgPfcChk,
  input  logic                cfgForward,
  output logic                lfcReq,
  output logic [15:0]         lfcQuanta,
  output logic                pfcReq,
  output logic [7:0]          pfcClassEn,
  output logic [127:0]        pfcQuanta
);
  hdr_t             hdrNow;
  logic [CNT_W-1:0] lenNow;
  strobe_t          strobe;

  mcf_control u_ctl (
    .inValid(inValid), .inLast(inLast), .inUser(inUser),
    .hdrNow(hdrNow), .lenNow(lenNow),
    .cfgEnable(cfgEnable),
    .cfgMcastAddr(cfgMcastAddr), .cfgMcastChk(cfgMcastChk),
    .cfgUcastAddr(cfgUcastAddr), .cfgUcastChk(cfgUcastChk),
    .cfgSrcAddr(cfgSrcAddr), .cfgSrcChk(cfgSrcChk),
    .cfgEthType(cfgEthType),
    .cfgLfcOpcode(cfgLfcOpcode), .cfgLfcChk(cfgLfcChk),
    .cfgPfcOpcode(cfgPfcOpcode), .cfgPfcChk(cfgPfcChk),
    .cfgForward(cfgForward),
    .strobe(strobe)
  );

  mcf_datapath u_dp (
    .clk(clk), .rst(rst),
    .inValid(inValid), .inData(inData), .inLast(inLast), .inUser(inUser),
    .strobe(strobe), .hdrNow(hdrNow), .lenNow(lenNow),
    .outValid(outValid), .outData(outData), .outLast(outLast), .outUser(outUser),
    .lfcReq(lfcReq), .lfcQuanta(lfcQuanta),
    .pfcReq(pfcReq), .pfcClassEn(pfcClassEn), .pfcQuanta(pfcQuanta)
  );
endmodule

// File: tb/test_mcf_rx_classifier.sv
`timescale 1ns/100ps
module test_mcf_rx_classifier;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, inValid, inLast, inUser;
  logic [7:0] inData;
  logic outValid, outLast, outUser;
  logic [7:0] outData;
  logic cfgEnable, cfgMcastChk, cfgUcastChk, cfgSrcChk, cfgLfcChk, cfgPfcChk, cfgForward;
  logic [47:0] cfgMcastAddr, cfgUcastAddr, cfgSrcAddr;
  logic [15:0] cfgEthType, cfgLfcOpcode, cfgPfcOpcode;
  logic lfcReq, pfcReq;
  logic [15:0] lfcQuanta;
  logic [7:0] pfcClassEn;
  logic [127:0] pfcQuanta;

  mcf_rx_classifier i_mcf_rx_classifier (.*);

  typedef struct packed {
    logic [7:0]   d;
    logic         l;
    logic         u;
    logic         lfc;
    logic         pfc;
    logic [15:0]  lq;
    logic [7:0]   ce;
    logic [127:0] pq;
  } beat_t;

  beat_t expQ[$];
  beat_t mb;
  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;
  string curTag = "init";
  logic [7:0] frm [64];

  localparam logic [47:0] MC  = 48'h0180C2000001;
  localparam logic [47:0] UC  = 48'hDAD1D2D3D4D5;
  localparam logic [47:0] SRC = 48'h5A5152535455;

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", req, curTag, act, exp);
    end
  endtask

  task automatic buildFrame(input logic [47:0] dst, input logic [47:0] src,
                            input logic [15:0] et, input logic [15:0] op);
    for (int i = 0; i < 64; i++) frm[i] = 8'(8'h20 + i);
    for (int b = 0; b < 6; b++) begin
      frm[b]     = dst[47-8*b -: 8];
      frm[6 + b] = src[47-8*b -: 8];
    end
    frm[12] = et[15:8]; frm[13] = et[7:0];
    frm[14] = op[15:8]; frm[15] = op[7:0];
  endtask

  // kind: 0 ordinary, 1 link pause, 2 class pause
  task automatic sendFrame(input int len, input bit usr, input int kind, input bit gap, input string tag);
    beat_t b;
    curTag = tag;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inData  = frm[i];
      inLast  = (i == len - 1);
      inUser  = (i == len - 1) ? usr : 1'b0;
      b = '0;
      b.d   = frm[i];
      b.l   = (i == len - 1);
      b.u   = b.l && (usr || (kind != 0 && !cfgForward));
      b.lfc = b.l && kind == 1 && !usr;
      b.pfc = b.l && kind == 2 && !usr;
      b.lq  = {frm[16], frm[17]};
      b.ce  = frm[17];
      for (int k = 0; k < 8; k++) b.pq[16*k +: 16] = {frm[18 + 2*k], frm[19 + 2*k]};
      expQ.push_back(b);
    end
    if (gap) begin
      @(negedge clk);
      inValid = 1'b0; inLast = 1'b0; inUser = 1'b0;
    end
  endtask

  // monitor: scoreboard comparison one cycle after each input beat
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected beat", 128'(outData), 128'h0);
        end else begin
          mb = expQ.pop_front();
          check(outData == mb.d && outLast == mb.l, "R2 data/last",
                128'({outData, outLast}), 128'({mb.d, mb.l}));
          check(outUser == mb.u, "R8 user mark", 128'(outUser), 128'(mb.u));
          check(lfcReq == mb.lfc, "R6 lfcReq", 128'(lfcReq), 128'(mb.lfc));
          check(pfcReq == mb.pfc, "R7 pfcReq", 128'(pfcReq), 128'(mb.pfc));
          if (mb.lfc) check(lfcQuanta == mb.lq, "R6 lfcQuanta", 128'(lfcQuanta), 128'(mb.lq));
          if (mb.pfc) begin
            check(pfcClassEn == mb.ce, "R7 pfcClassEn", 128'(pfcClassEn), 128'(mb.ce));
            check(pfcQuanta == mb.pq, "R7 pfcQuanta", pfcQuanta, mb.pq);
          end
        end
      end else if (lfcReq || pfcReq) begin
        check(1'b0, "R11 request without beat", 128'({lfcReq, pfcReq}), 128'h0);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; inValid = 1'b0; inData = '0; inLast = 1'b0; inUser = 1'b0;
    cfgEnable = 1'b1; cfgMcastAddr = MC; cfgMcastChk = 1'b1;
    cfgUcastAddr = UC; cfgUcastChk = 1'b0; cfgSrcAddr = SRC; cfgSrcChk = 1'b0;
    cfgEthType = 16'h8808; cfgLfcOpcode = 16'h0001; cfgLfcChk = 1'b1;
    cfgPfcOpcode = 16'h0101; cfgPfcChk = 1'b1; cfgForward = 1'b0;
    repeat (4) @(negedge clk);
    check(!outValid && !lfcReq && !pfcReq, "R1 reset outputs", 128'({outValid, lfcReq, pfcReq}), 128'h0);
    rst = 1'b0;
    @(negedge clk);
    check(!outValid && !lfcReq && !pfcReq, "R1 after reset", 128'({outValid, lfcReq, pfcReq}), 128'h0);

    // R2: ordinary frame, and one arriving with a bad FCS
    buildFrame(UC, SRC, 16'h0800, 16'h0001);
    sendFrame(40, 1'b0, 0, 1'b1, "R2 data");
    sendFrame(40, 1'b1, 0, 1'b1, "R2 data bad fcs");
    // R6 / R8: link pause, marked bad
    buildFrame(MC, SRC, 16'h8808, 16'h0001);
    sendFrame(60, 1'b0, 1, 1'b1, "R6 link pause");
    // R7: class pause
    buildFrame(MC, SRC, 16'h8808, 16'h0101);
    sendFrame(60, 1'b0, 2, 1'b1, "R7 class pause");
    // R9: bad FCS suppresses request but still marks
    buildFrame(MC, SRC, 16'h8808, 16'h0001);
    sendFrame(60, 1'b1, 1, 1'b1, "R9 link bad fcs");
    // R10: length boundaries
    sendFrame(17, 1'b0, 0, 1'b1, "R10 link 17 bytes");
    sendFrame(18, 1'b0, 1, 1'b1, "R10 link 18 bytes");
    buildFrame(MC, SRC, 16'h8808, 16'h0101);
    sendFrame(33, 1'b0, 0, 1'b1, "R10 class 33 bytes");
    sendFrame(34, 1'b0, 2, 1'b1, "R10 class 34 bytes");
    // R4: unicast destination
    buildFrame(UC, SRC, 16'h8808, 16'h0001);
    sendFrame(60, 1'b0, 0, 1'b1, "R4 ucast not enabled");
    cfgUcastChk = 1'b1;
    sendFrame(60, 1'b0, 1, 1'b1, "R4 ucast enabled");
    cfgMcastChk = 1'b0; cfgUcastChk = 1'b0;
    buildFrame(48'h112233445566, SRC, 16'h8808, 16'h0001);
    sendFrame(60, 1'b0, 1, 1'b1, "R4 no dst check");
    cfgMcastChk = 1'b1;
    // R5: source compare
    cfgSrcChk = 1'b1;
    buildFrame(MC, 48'hA0A1A2A3A4A5, 16'h8808, 16'h0001);
    sendFrame(60, 1'b0, 0, 1'b1, "R5 wrong src");
    buildFrame(MC, SRC, 16'h8808, 16'h0001);
    sendFrame(60, 1'b0, 1, 1'b1, "R5 right src");
    cfgSrcChk = 1'b0;
    // R6: link decode disabled
    cfgLfcChk = 1'b0;
    sendFrame(60, 1'b0, 0, 1'b1, "R6 link decode off");
    cfgLfcChk = 1'b1;
    // R8: forwarding on
    cfgForward = 1'b1;
    sendFrame(60, 1'b0, 1, 1'b1, "R8 forward link");
    buildFrame(MC, SRC, 16'h8808, 16'h0101);
    sendFrame(60, 1'b0, 2, 1'b1, "R8 forward class");
    cfgForward = 1'b0;
    // R3: wrong EtherType, master enable off
    buildFrame(MC, SRC, 16'h8809, 16'h0001);
    sendFrame(60, 1'b0, 0, 1'b1, "R3 wrong ethertype");
    buildFrame(MC, SRC, 16'h8808, 16'h0001);
    cfgEnable = 1'b0;
    sendFrame(60, 1'b0, 0, 1'b1, "R3 disabled");
    cfgEnable = 1'b1;
    // R11: back to back link then class then data with no idle gap
    sendFrame(20, 1'b0, 1, 1'b0, "R11 b2b link");
    buildFrame(MC, SRC, 16'h8808, 16'h0101);
    sendFrame(36, 1'b0, 2, 1'b0, "R11 b2b class");
    buildFrame(UC, SRC, 16'h0800, 16'h0101);
    sendFrame(30, 1'b0, 0, 1'b1, "R11 b2b data");

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R2 all beats out", 128'(expQ.size()), 128'h0);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule